// File: doc/BRIEF.md
# DMA Channel Interrupt Aggregator

This block gathers the completion events of a multi-channel DMA engine into one interrupt line. Every channel signals three kinds of event as single-cycle pulses: half of a transfer done, one packet done, and the whole queue done. Each pulse sets a sticky status bit. Status bits are gated by matching enable bits, and the result drives one registered, level-sensitive interrupt output.

Software reaches the block through a simple register port that has a write strobe and one cycle of read latency. A channel owns a four-bit field, and eight channels share each 32-bit register. With 16 channels there are two enable registers and two status registers. An interrupt handler reads a status register, then writes the same value back to acknowledge exactly the events it saw. Events that arrive in the meantime stay pending. A separate read-only word reports which channels are busy.

Top module: `dma_irq_hub`

## Requirements
- R1: After a synchronous reset, all enable and status bits are zero, the read data is zero and `irq` is low.
- R2: A pulse on `evt_half[c]`, `evt_pkt[c]` or `evt_queue[c]` sets status bit 0, 1 or 2 of the field at bit 4*(c mod 8). That field lives in the status word at offset 0x10 + 4*(c/8). The bit is set on the clock edge that samples the pulse, whether or not the matching enable bit is set.
- R3: A write to a status word clears each status bit whose write-data bit is 1. Bits whose write-data bit is 0 keep their value.
- R4: If an event and a write-1 clear of the same status bit arrive in the same cycle, the bit ends up set.
- R5: `irq` is a registered level. It is high in the cycle after any status bit and its matching enable bit are both 1, and low in the cycle after no such pair exists.
- R6: Enable words at offsets 0x00 + 4*k are writable and read back what was written. Bit 3 of every field, in both enable and status words, always reads 0. `bus_rdata` shows the word addressed one clock edge earlier.
- R7: The word at offset 0x30 returns `ch_active[c]` at bit c, and zero in all higher bits.
- R8: Writing zero to every enable word drives `irq` low one cycle after the enable update. Pending status bits are kept.
- R9: Offsets that map to no register read as zero. Writes to those offsets change no enable or status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_half | input | NUM_CH | Half-transfer event pulse per channel |
| evt_pkt | input | NUM_CH | Packet-done event pulse per channel |
| evt_queue | input | NUM_CH | Queue-done event pulse per channel |
| ch_active | input | NUM_CH | Busy level per channel |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Registered level interrupt |

## Verification
The assertions check the following on every cycle:
- every event pulse appears in status on the next edge;
- a status bit falls only when a clear write carrying a 1 at that position occurred;
- the reserved field bits stay zero;
- `irq` follows the masked OR one cycle later;
- the busy word mirrors `ch_active`.

Only the bench scenarios can show the other behaviours:
- the exact offset and bit position of each channel's field, including the second register pair;
- an event surviving a clear in the same cycle;
- the enable read-back;
- silencing by zeroing the enables while status is retained;
- unmapped offsets being inert.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int GRP_CH  = 8;
  localparam int FLD_W   = 4;
  localparam int WORD_W  = 32;
  localparam int OFS_EN  = 'h00;
  localparam int OFS_ST  = 'h10;
  localparam int OFS_BSY = 'h30;
  localparam logic [WORD_W-1:0] FLD_MASK = 32'h7777_7777;
endpackage

// File: rtl/irq_bank.sv
module irq_bank
  import dma_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [GRP_CH-1:0] ev_half,
  input  logic [GRP_CH-1:0] ev_pkt,
  input  logic [GRP_CH-1:0] ev_queue,
  input  logic              en_wr,
  input  logic              st_wr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] en_q,
  output logic [WORD_W-1:0] st_q,
  output logic              hit
);
  logic [WORD_W-1:0] ev_vec;
  logic [WORD_W-1:0] clr_vec;

  genvar c;
  generate
    for (c = 0; c < GRP_CH; c++) begin : g_fld
      assign ev_vec[c*FLD_W +: FLD_W] = {1'b0, ev_queue[c], ev_pkt[c], ev_half[c]};
    end
  endgenerate

  assign clr_vec = st_wr ? (wdata & FLD_MASK) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
      st_q <= '0;
    end else begin
      if (en_wr) en_q <= wdata & FLD_MASK;
      // a new event wins over a clear in the same cycle
      st_q <= (st_q & ~clr_vec) | ev_vec;
    end
  end

  assign hit = |(en_q & st_q);
endmodule

// File: rtl/irq_line.sv
module irq_line #(
  parameter int NHIT = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NHIT-1:0] hits,
  output logic            irq
);
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |hits;
  end
endmodule

// File: rtl/dma_irq_hub.sv
module dma_irq_hub
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] evt_half,
  input  logic [NUM_CH-1:0] evt_pkt,
  input  logic [NUM_CH-1:0] evt_queue,
  input  logic [NUM_CH-1:0] ch_active,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  localparam int NGRP  = NUM_CH / GRP_CH;
  localparam int ALL_W = NUM_CH * FLD_W;

  logic [ALL_W-1:0] en_all;
  logic [ALL_W-1:0] st_all;
  logic [NGRP-1:0]  grp_hit;
  logic [31:0]      rd_next;

  genvar g;
  generate
    for (g = 0; g < NGRP; g++) begin : g_bank
      logic en_wr, st_wr;
      assign en_wr = bus_wr && (int'(bus_addr) == OFS_EN + 4*g);
      assign st_wr = bus_wr && (int'(bus_addr) == OFS_ST + 4*g);
      irq_bank u_bank (
        .clk      (clk),
        .rst      (rst),
        .ev_half  (evt_half [g*GRP_CH +: GRP_CH]),
        .ev_pkt   (evt_pkt  [g*GRP_CH +: GRP_CH]),
        .ev_queue (evt_queue[g*GRP_CH +: GRP_CH]),
        .en_wr    (en_wr),
        .st_wr    (st_wr),
        .wdata    (bus_wdata),
        .en_q     (en_all[g*WORD_W +: WORD_W]),
        .st_q     (st_all[g*WORD_W +: WORD_W]),
        .hit      (grp_hit[g])
      );
    end
  endgenerate

  irq_line #(.NHIT(NGRP)) u_line (
    .clk  (clk),
    .rst  (rst),
    .hits (grp_hit),
    .irq  (irq)
  );

  always_comb begin
    rd_next = '0;
    for (int k = 0; k < NGRP; k++) begin
      if (int'(bus_addr) == OFS_EN + 4*k) rd_next = en_all[k*WORD_W +: WORD_W];
      if (int'(bus_addr) == OFS_ST + 4*k) rd_next = st_all[k*WORD_W +: WORD_W];
    end
    if (int'(bus_addr) == OFS_BSY) rd_next[NUM_CH-1:0] = ch_active;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end
endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int ADDR_W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic [NUM_CH-1:0]   evt_half,
  input logic [NUM_CH-1:0]   evt_pkt,
  input logic [NUM_CH-1:0]   evt_queue,
  input logic [NUM_CH-1:0]   ch_active,
  input logic                bus_wr,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [31:0]         bus_wdata,
  input logic [31:0]         bus_rdata,
  input logic                irq,
  input logic [NUM_CH*4-1:0] en_all,
  input logic [NUM_CH*4-1:0] st_all
);
  localparam int NGRP  = NUM_CH / GRP_CH;
  localparam int ALL_W = NUM_CH * FLD_W;

  logic [ALL_W-1:0] ev_vec;
  logic [ALL_W-1:0] clr_vec;
  logic [ALL_W-1:0] rsv_mask;

  genvar c, g;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_ev
      assign ev_vec[c*4 +: 4]   = {1'b0, evt_queue[c], evt_pkt[c], evt_half[c]};
      assign rsv_mask[c*4 +: 4] = 4'b1000;
    end
    for (g = 0; g < NGRP; g++) begin : g_clr
      assign clr_vec[g*32 +: 32] =
        (bus_wr && int'(bus_addr) == OFS_ST + 4*g) ? bus_wdata : 32'h0;
    end
  endgenerate

  // R1
  reset_quiet_chk: assert property (@(posedge clk) $past(rst) |-> (!irq && bus_rdata == 32'h0));

  // R2
  event_latch_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_vec != '0) |=> ((st_all & $past(ev_vec)) == $past(ev_vec)));

  // R3
  clear_only_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(st_all) & ~$past(clr_vec)) & ~st_all) == '0));

  // R5
  irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
    ((en_all & st_all) != '0) |=> irq);

  // R5
  irq_fall_chk: assert property (@(posedge clk) disable iff (rst)
    ((en_all & st_all) == '0) |=> !irq);

  // R6
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ((en_all & rsv_mask) == '0) && ((st_all & rsv_mask) == '0));

  // R7
  busy_word_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(bus_addr) == OFS_BSY) |=> (bus_rdata == 32'($past(ch_active))));
endmodule

bind dma_irq_hub irq_hub_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/dma_irq_hub_test.sv
module dma_irq_hub_test;
  localparam int NUM_CH = 16;
  localparam int ADDR_W = 8;

  logic              clk = 1'b0;
  logic              rst;
  logic [NUM_CH-1:0] evt_half, evt_pkt, evt_queue, ch_active;
  logic              bus_wr;
  logic [ADDR_W-1:0] bus_addr;
  logic [31:0]       bus_wdata, bus_rdata;
  logic              irq;

  int n_run  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  dma_irq_hub #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) uut (.*);

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = ADDR_W'(a);
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic pulse(input int kind, input int ch);
    @(negedge clk);
    case (kind)
      0: evt_half[ch]  = 1'b1;
      1: evt_pkt[ch]   = 1'b1;
      default: evt_queue[ch] = 1'b1;
    endcase
    @(negedge clk);
    evt_half = '0; evt_pkt = '0; evt_queue = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 rdata", bus_rdata, 32'h0);
    rd('h00, d); check("R1 en0", d, 32'h0);
    rd('h14, d); check("R1 st1", d, 32'h0);
  endtask

  task automatic t_latch();
    logic [31:0] d;
    pulse(0, 3);
    pulse(1, 3);
    pulse(2, 12);
    rd('h10, d); check("R2 st0 ch3 half+pkt", d, 32'h0000_3000);
    rd('h14, d); check("R2 st1 ch12 queue", d, 32'h0004_0000);
    check("R2 no irq while disabled", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    wr('h10, 32'h0000_1000);
    rd('h10, d); check("R3 partial clear", d, 32'h0000_2000);
    wr('h10, 32'h0000_2000);
    wr('h14, 32'h0004_0000);
    rd('h10, d); check("R3 st0 cleared", d, 32'h0);
    rd('h14, d); check("R3 st1 cleared", d, 32'h0);
  endtask

  task automatic t_collision();
    logic [31:0] d;
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'h10; bus_wdata = 32'h1; evt_half[0] = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0; evt_half = '0;
    rd('h10, d); check("R4 event beats clear", d, 32'h1);
    wr('h10, 32'h1);
    rd('h10, d); check("R4 later clear", d, 32'h0);
  endtask

  task automatic t_enable_rw();
    logic [31:0] d;
    wr('h00, 32'hFFFF_FFFF);
    rd('h00, d); check("R6 en0 bit3 masked", d, 32'h7777_7777);
    wr('h00, 32'h0);
    wr('h04, 32'h0000_0040);
    rd('h04, d); check("R6 en1 readback", d, 32'h0000_0040);
  endtask

  task automatic t_irq();
    pulse(2, 8);
    check("R5 irq low before registered", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R5 irq not for ch8", {31'b0, irq}, 32'h0);
    pulse(2, 9);
    @(negedge clk);
    check("R5 irq from ch9 queue", {31'b0, irq}, 32'h1);
    wr('h14, 32'h0000_0040);
    @(negedge clk);
    check("R5 irq drops after clear", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_silence();
    logic [31:0] d;
    wr('h00, 32'h0000_0002);
    pulse(1, 0);
    @(negedge clk);
    check("R8 irq raised", {31'b0, irq}, 32'h1);
    wr('h00, 32'h0);
    wr('h04, 32'h0);
    @(negedge clk);
    check("R8 irq silenced", {31'b0, irq}, 32'h0);
    rd('h10, d); check("R8 status kept", d, 32'h0000_0002);
  endtask

  task automatic t_global();
    logic [31:0] d;
    ch_active = 16'hA5C3;
    rd('h30, d); check("R7 busy word", d, 32'h0000_A5C3);
    ch_active = 16'h0001;
    rd('h30, d); check("R7 busy word update", d, 32'h0000_0001);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr('h08, 32'hFFFF_FFFF);
    wr('h18, 32'hFFFF_FFFF);
    rd('h08, d); check("R9 unmapped read", d, 32'h0);
    rd('h00, d); check("R9 en0 untouched", d, 32'h0);
    rd('h10, d); check("R9 st0 untouched", d, 32'h0000_0002);
  endtask

  initial begin
    rst = 1'b1; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    evt_half = '0; evt_pkt = '0; evt_queue = '0; ch_active = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_latch();
    t_clear();
    t_collision();
    t_enable_rw();
    t_irq();
    t_silence();
    t_global();
    t_unmapped();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule